// File: doc/BRIEF.md
# Configurable Interrupt Status Field

This block holds one multi-bit interrupt status field. A hardware event vector comes in on one side and software clears bits with a write-one-to-clear strobe on the other. Two elaboration parameters set its behaviour. The detection parameter chooses level, rising-edge, falling-edge or any-edge sensing. The storage parameter chooses one of three modes: pulse (no latching), per-bit sticky, or whole-value sticky, which captures a non-zero value once and holds it. Whole-value sticky cannot be combined with edge sensing, and elaboration stops with an error if it is asked for.

Two selection vectors decide which stored bits reach the `irq` and `halt` outputs. The halt output acts as a second priority level. A parameter sets whether each selection vector is read as an enable (1 passes the bit) or as a mask (1 blocks the bit). By default the `irq` selection is an enable and the `halt` selection is a mask. The outputs are the OR of the selected stored bits and have no register stage after the status flops.

Top module: `isf_field`

## Requirements
- R1: With level sensing and pulse storage, `status` one cycle after a clock edge equals `evt_in` as sampled at that edge, minus any bits cleared there.
- R2: With rising-edge sensing and pulse storage, a status bit is 1 for exactly the one cycle after the edge where its input went from 0 to 1 between consecutive clock samples.
- R3: With falling-edge sensing and pulse storage, a status bit is 1 for exactly one cycle after its input goes from 1 to 0.
- R4: With any-edge sensing and pulse storage, a status bit is 1 for one cycle after each change of its input.
- R5: With per-bit sticky storage, each status bit is set by a 1 on its event and stays set until software clears it.
- R6: With whole-value sticky storage, an all-zero field loads the whole event vector when that vector is non-zero. A non-zero field ignores the event input until software has cleared all of its bits.
- R7: A field one bit wide in whole-value sticky mode behaves exactly like per-bit sticky mode.
- R8: When `clr_we` is 1, every status bit where `clr_data` is 1 reads 0 in the next cycle, even if an event sets that bit in the same cycle. When `clr_we` is 0, `clr_data` has no effect.
- R9: With the enable reading, `irq` is 1 exactly when some status bit is 1 and has its `irq_sel` bit at 1.
- R10: With the mask reading, `halt` is 1 exactly when some status bit is 1 and has its `halt_sel` bit at 0.
- R11: Synchronous active-low reset clears `status`. An input that is already high when reset is released produces no edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | WIDTH | Hardware event vector |
| clr_we | input | 1 | Software clear strobe |
| clr_data | input | WIDTH | Clear pattern, a 1 clears that bit |
| irq_sel | input | WIDTH | Selection vector for the irq output |
| halt_sel | input | WIDTH | Selection vector for the halt output |
| status | output | WIDTH | Stored status field |
| irq | output | 1 | OR of status bits selected for interrupt |
| halt | output | 1 | OR of status bits selected for halt |

## Verification
Six copies of the field run side by side on one shared event and clear stream, one copy for each detection and storage mode, plus a one-bit whole-value copy. The stream contains several distinct patterns:
- A first non-zero value, a partial change and a held value. These separate rising, falling and any-edge pulses from level tracking.
- A second value that arrives while the whole-value copy is still full. This separates per-bit accumulation from capture-once latching.
- A clear that lands on a bit being set in the same cycle, and clear data presented without its strobe.

Directed steps then switch the selection vectors under a fixed status to show the enable and mask readings. A final step holds the input high through a reset release to show that no false edge appears.

// File: rtl/isf_pkg.sv
// Package isf_pkg
// Shared encodings for the interrupt status field: how the event input is
// sensed and how the sensed event is stored.
package isf_pkg;

    // Event sensing choice
    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_RISE  = 2'd1,
        DET_FALL  = 2'd2,
        DET_BOTH  = 2'd3
    } det_e;

    // Storage choice
    typedef enum logic [1:0] {
        ST_PULSE = 2'd0,  // no latching
        ST_BITS  = 2'd1,  // each bit latches on its own
        ST_WORD  = 2'd2   // whole value captured once
    } store_e;

endpackage

// File: rtl/isf_edge.sv
// Module isf_edge
// Turns an event vector into per-bit edge events (rising, falling or any).
// Assumes DETECT is one of the edge choices; level sensing bypasses this block.
// The previous-sample register resets to zero. An arm flag holds events off
// for the first cycle after reset, so an input already high then is not an edge.
module isf_edge
    import isf_pkg::*;
#(
    parameter int   WIDTH  = 8,
    parameter det_e DETECT = DET_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_in,
    output logic [WIDTH-1:0] edge_ev
);

    logic [WIDTH-1:0] prev_q;
    logic             armed_q;
    logic [WIDTH-1:0] raw_ev;

    // Keep last cycle's input and note that one sample has been taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= evt_in;
            armed_q <= 1'b1;
        end
    end

    // Pick the edge equation chosen by the parameter
    generate
        if (DETECT == DET_RISE) begin : g_rise
            assign raw_ev = ~prev_q & evt_in;
        end else if (DETECT == DET_FALL) begin : g_fall
            assign raw_ev = prev_q & ~evt_in;
        end else if (DETECT == DET_BOTH) begin : g_both
            assign raw_ev = prev_q ^ evt_in;
        end else begin : g_bad
            $error("isf_edge: DETECT must select an edge mode");
            assign raw_ev = prev_q & evt_in;
        end
    endgenerate

    // Hold events off until the first post-reset sample exists
    always_comb begin
        edge_ev = raw_ev & {WIDTH{armed_q}};
    end

    // No event may come out in the first cycle after reset
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(edge_ev) == '0) else $error("AST_QUIET_AFTER_RESET"); // R11

endmodule

// File: rtl/isf_store.sv
// Module isf_store
// Holds the status field. Applies the storage rule chosen by STORE, then the
// software clear, which always wins over a set in the same cycle.
// A one-bit field in whole-value mode is built as per-bit sticky.
module isf_store
    import isf_pkg::*;
#(
    parameter int     WIDTH = 8,
    parameter store_e STORE = ST_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ev,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_data,
    output logic [WIDTH-1:0] status
);

    localparam store_e EFF_STORE = (STORE == ST_WORD && WIDTH == 1) ? ST_BITS : STORE;

    logic [WIDTH-1:0] set_val;
    logic [WIDTH-1:0] clr_mask;

    // Clear pattern only counts while the strobe is high
    always_comb begin
        clr_mask = clr_we ? clr_data : '0;
    end

    // Value before clearing, per storage rule
    generate
        if (EFF_STORE == ST_PULSE) begin : g_pulse
            assign set_val = ev;
        end else if (EFF_STORE == ST_BITS) begin : g_bits
            assign set_val = status | ev;

            // A set bit survives any cycle without a clear
            AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_we |=> (status & $past(status)) == $past(status))
                else $error("AST_BITS_HOLD"); // R5
        end else begin : g_word
            logic empty;
            assign empty   = (status == '0);
            assign set_val = (empty && ev != '0) ? ev : status;

            // A captured value does not move until software clears
            AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                (status != '0 && !clr_we) |=> $stable(status))
                else $error("AST_WORD_FROZEN"); // R6
        end
    endgenerate

    // Status register: reset, then rule result with clears applied last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= set_val & ~clr_mask;
        end
    end

    // A cleared bit reads zero in the following cycle
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (status & $past(clr_data)) == '0) else $error("AST_CLEAR_WINS"); // R8

endmodule

// File: rtl/isf_select.sv
// Module isf_select
// Reduces the status field to one output bit through a selection vector.
// AS_MASK=0: a 1 in sel passes the bit. AS_MASK=1: a 1 in sel blocks it.
module isf_select #(
    parameter int WIDTH   = 8,
    parameter bit AS_MASK = 1'b0
) (
    input  logic [WIDTH-1:0] status,
    input  logic [WIDTH-1:0] sel,
    output logic             hit
);

    logic [WIDTH-1:0] pass;

    // Turn the selection into a pass vector by polarity
    generate
        if (AS_MASK) begin : g_mask
            assign pass = ~sel;
        end else begin : g_enable
            assign pass = sel;
        end
    endgenerate

    // OR of all passed status bits
    always_comb begin
        hit = |(status & pass);
    end

endmodule

// File: rtl/isf_field.sv
// Module isf_field
// Top of the interrupt status field: sensing, storage and two output selections.
// Assumes evt_in is already synchronous to clk.
// Whole-value storage combined with edge sensing is rejected at elaboration.
module isf_field
    import isf_pkg::*;
#(
    parameter int     WIDTH            = 8,
    parameter det_e   DETECT           = DET_LEVEL,
    parameter store_e STORE            = ST_BITS,
    parameter bit     IRQ_SEL_IS_MASK  = 1'b0,
    parameter bit     HALT_SEL_IS_MASK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_in,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_data,
    input  logic [WIDTH-1:0] irq_sel,
    input  logic [WIDTH-1:0] halt_sel,
    output logic [WIDTH-1:0] status,
    output logic             irq,
    output logic             halt
);

    localparam bit IS_EDGE = (DETECT != DET_LEVEL);

    logic [WIDTH-1:0] ev;

    // Sensing path: direct for level, edge block otherwise
    generate
        if (IS_EDGE && STORE == ST_WORD && WIDTH > 1) begin : g_reject
            $error("isf_field: whole-value storage cannot use edge sensing");
        end
        if (IS_EDGE) begin : g_edge
            isf_edge #(
                .WIDTH  (WIDTH),
                .DETECT (DETECT)
            ) i_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .evt_in  (evt_in),
                .edge_ev (ev)
            );
        end else begin : g_level
            assign ev = evt_in;
        end
    endgenerate

    isf_store #(
        .WIDTH (WIDTH),
        .STORE (STORE)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .status   (status)
    );

    isf_select #(
        .WIDTH   (WIDTH),
        .AS_MASK (IRQ_SEL_IS_MASK)
    ) i_irq_sel (
        .status (status),
        .sel    (irq_sel),
        .hit    (irq)
    );

    isf_select #(
        .WIDTH   (WIDTH),
        .AS_MASK (HALT_SEL_IS_MASK)
    ) i_halt_sel (
        .status (status),
        .sel    (halt_sel),
        .hit    (halt)
    );

    // Mode-specific checks on the stored field
    generate
        if (DETECT == DET_LEVEL && STORE == ST_PULSE) begin : g_chk_level
            AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_we |=> status == $past(evt_in)) else $error("AST_LEVEL_FOLLOWS"); // R1
        end
        if ((DETECT == DET_RISE || DETECT == DET_FALL) && STORE == ST_PULSE) begin : g_chk_pulse
            AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                (status != '0) |=> (status & $past(status)) == '0)
                else $error("AST_PULSE_ONE_CYCLE"); // R2
        end
    endgenerate

    // An empty field can drive neither output
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (!irq && !halt)) else $error("AST_IDLE_OUTPUTS"); // R9

endmodule

// File: tb/test_isf_field.sv
// Bench for isf_field: six copies in different modes share one stimulus stream.
module test_isf_field;
    import isf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int NVEC       = 9;

    // Vector fields: evt, clr_we, clr_data, then expected level, rise, fall, both, bits, word
    localparam logic [32:0] VEC [NVEC] = '{
        {4'b0011, 1'b0, 4'b0000, 4'b0011, 4'b0011, 4'b0000, 4'b0011, 4'b0011, 4'b0011},
        {4'b0110, 1'b0, 4'b0000, 4'b0110, 4'b0100, 4'b0001, 4'b0101, 4'b0111, 4'b0011},
        {4'b0110, 1'b0, 4'b0000, 4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0111, 4'b0011},
        {4'b0000, 1'b1, 4'b0001, 4'b0000, 4'b0000, 4'b0110, 4'b0110, 4'b0110, 4'b0010},
        {4'b1000, 1'b1, 4'b0010, 4'b1000, 4'b1000, 4'b0000, 4'b1000, 4'b1100, 4'b0000},
        {4'b1001, 1'b0, 4'b0000, 4'b1001, 4'b0001, 4'b0000, 4'b0001, 4'b1101, 4'b1001},
        {4'b0100, 1'b0, 4'b1111, 4'b0100, 4'b0100, 4'b1001, 4'b1101, 4'b1101, 4'b1001},
        {4'b0000, 1'b1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'b1111, 1'b1, 4'b0101, 4'b1010, 4'b1010, 4'b0000, 4'b1010, 4'b1010, 4'b1010}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] evt;
    logic         clr_we;
    logic [W-1:0] clr_data;
    logic [W-1:0] irq_sel;
    logic [W-1:0] halt_sel;

    logic [W-1:0] st_lvl, st_rise, st_fall, st_both, st_bits, st_word;
    logic [0:0]   st_one;
    logic         irq_lvl, halt_lvl;
    logic         irq_rise, halt_rise, irq_fall, halt_fall, irq_both, halt_both;
    logic         irq_bits, halt_bits, irq_word, halt_word, irq_one, halt_one;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    isf_field #(.WIDTH(W), .DETECT(DET_LEVEL), .STORE(ST_PULSE)) i_isf_field (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .clr_we(clr_we), .clr_data(clr_data),
        .irq_sel(irq_sel), .halt_sel(halt_sel), .status(st_lvl), .irq(irq_lvl), .halt(halt_lvl));
    isf_field #(.WIDTH(W), .DETECT(DET_RISE), .STORE(ST_PULSE)) i_isf_field_rise (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .clr_we(clr_we), .clr_data(clr_data),
        .irq_sel(irq_sel), .halt_sel(halt_sel), .status(st_rise), .irq(irq_rise), .halt(halt_rise));
    isf_field #(.WIDTH(W), .DETECT(DET_FALL), .STORE(ST_PULSE)) i_isf_field_fall (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .clr_we(clr_we), .clr_data(clr_data),
        .irq_sel(irq_sel), .halt_sel(halt_sel), .status(st_fall), .irq(irq_fall), .halt(halt_fall));
    isf_field #(.WIDTH(W), .DETECT(DET_BOTH), .STORE(ST_PULSE)) i_isf_field_both (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .clr_we(clr_we), .clr_data(clr_data),
        .irq_sel(irq_sel), .halt_sel(halt_sel), .status(st_both), .irq(irq_both), .halt(halt_both));
    isf_field #(.WIDTH(W), .DETECT(DET_LEVEL), .STORE(ST_BITS)) i_isf_field_bits (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .clr_we(clr_we), .clr_data(clr_data),
        .irq_sel(irq_sel), .halt_sel(halt_sel), .status(st_bits), .irq(irq_bits), .halt(halt_bits));
    isf_field #(.WIDTH(W), .DETECT(DET_LEVEL), .STORE(ST_WORD)) i_isf_field_word (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .clr_we(clr_we), .clr_data(clr_data),
        .irq_sel(irq_sel), .halt_sel(halt_sel), .status(st_word), .irq(irq_word), .halt(halt_word));
    isf_field #(.WIDTH(1), .DETECT(DET_LEVEL), .STORE(ST_WORD)) i_isf_field_one (
        .clk(clk), .rst_n(rst_n), .evt_in(evt[0]), .clr_we(clr_we), .clr_data(clr_data[0]),
        .irq_sel(irq_sel[0]), .halt_sel(halt_sel[0]), .status(st_one), .irq(irq_one), .halt(halt_one));

    // Compare one value and report a mismatch
    task automatic check(input string req, input string what, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        wait (cycles >= 5000);
        failures++;
        $display("FAIL watchdog: actual=%0d cycles expected=under 5000", cycles);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; evt = '0; clr_we = 1'b0; clr_data = '0; irq_sel = '0; halt_sel = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "level status in reset", st_lvl, 4'b0000);
        check("R11", "bits status in reset", st_bits, 4'b0000);
        check("R11", "irq in reset", {3'b000, irq_lvl}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk); // one idle cycle arms the edge sensing

        // Table walk: each vector is applied for one edge, results read one edge later
        for (int i = 0; i < NVEC; i++) begin
            evt      = VEC[i][32:29];
            clr_we   = VEC[i][28];
            clr_data = VEC[i][27:24];
            @(negedge clk);
            check("R1", $sformatf("level step %0d", i), st_lvl,  VEC[i][23:20]);
            check("R2", $sformatf("rise step %0d", i),  st_rise, VEC[i][19:16]);
            check("R3", $sformatf("fall step %0d", i),  st_fall, VEC[i][15:12]);
            check("R4", $sformatf("both step %0d", i),  st_both, VEC[i][11:8]);
            check("R5", $sformatf("bits step %0d", i),  st_bits, VEC[i][7:4]);
            check("R6", $sformatf("word step %0d", i),  st_word, VEC[i][3:0]);
            check("R7", $sformatf("one-bit word step %0d", i), {3'b000, st_one}, {3'b000, VEC[i][4]});
        end
        // R8: explicit clear-priority and strobe-gating points from the table
        check("R8", "bits cleared bit wins over set", st_bits & 4'b0101, 4'b0000);

        // Selection outputs with level status fixed at 0100
        clr_we = 1'b0; clr_data = '0; evt = 4'b0100;
        @(negedge clk);
        irq_sel = 4'b0100; #1;
        check("R9", "irq enabled bit", {3'b000, irq_lvl}, 4'b0001);
        irq_sel = 4'b1011; #1;
        check("R9", "irq bit not enabled", {3'b000, irq_lvl}, 4'b0000);
        halt_sel = 4'b1011; #1;
        check("R10", "halt bit not masked", {3'b000, halt_lvl}, 4'b0001);
        halt_sel = 4'b0100; #1;
        check("R10", "halt bit masked", {3'b000, halt_lvl}, 4'b0000);

        // Input held high across a reset release
        @(negedge clk);
        evt = 4'b1111; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11", "rise status in reset", st_rise, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "rise after release", st_rise, 4'b0000);
        check("R11", "both after release", st_both, 4'b0000);
        check("R1", "level after release", st_lvl, 4'b1111);
        @(negedge clk);
        check("R11", "rise second cycle", st_rise, 4'b0000);
        finish_run();
    end

endmodule